// File: doc/BRIEF.md
# Parameter-Splicing Serial Boot Loader

This block boots up to four rate-generator targets from one shared boot image held in a small internal ROM. A host writes a phase word and a rate word into local registers. It then issues a boot command that names one target. The loader streams every word of the image to that target over a serial link. As the words pass, it replaces two fixed word positions with the stored phase and rate values. No patched copy of the image is ever stored.

The host drives a one-cycle command port with four operations. Each boot captures the current phase, rate and divider values, so the host may change them while a transfer is running without disturbing it. During a transfer the loader raises the chosen target's select line and drives data most significant bit first with a bit clock. Afterwards it returns to idle, pulses done and leaves that target untouched until another boot command names it. A boot command that arrives while a transfer is in progress is refused and flagged.

Top module: `param_splice_loader`

## Requirements
- R1: After reset, `tgt_sel` is all zero and `busy`, `done`, `boot_err` and `ser_clk` are all low.
- R2: Command encoding on `cmd_op`: 2'b00 stores `cmd_data` as the phase word, 2'b01 stores it as the rate word, 2'b11 stores its low `DIV_W` bits as the divider, and 2'b10 boots target `cmd_tgt`. The image word at index `PHASE_SLOT` is sent as the phase word and the word at index `RATE_SLOT` is sent as the rate word.
- R3: Each other image word k is the low `WORD_W` bits of (k * 0x1357) XOR 0xC0DE. Words are sent in index order 0 to `IMG_WORDS`-1.
- R4: Each word is sent most significant bit first. A bit is valid at the rising edge of `ser_clk` and stays stable while `ser_clk` is high.
- R5: With divider value D captured at boot, each high phase of `ser_clk` lasts D+1 clock cycles.
- R6: During a transfer, exactly the select line of the booted target is high and it does not change. When idle, all select lines are low and `ser_clk` is low. A booted target sees no further activity until it is booted again.
- R7: `busy` goes high on the clock edge that accepts a boot command and stays high until the transfer ends.
- R8: `done` is a one-cycle pulse, given exactly once per boot, in the cycle after the final bit's high phase ends. In that same cycle `busy` and `tgt_sel` return low.
- R9: A boot command received while `busy` is high is ignored. `boot_err` is high for exactly the one cycle after that command, and the running transfer continues to its original target with its original content.
- R10: Phase, rate and divider writes made during a transfer do not change that transfer. They apply to the next boot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Host command strobe, one cycle per command |
| cmd_op | input | 2 | Command operation (see R2) |
| cmd_tgt | input | $clog2(NUM_TGT) | Target index for a boot command |
| cmd_data | input | WORD_W | Phase, rate or divider value |
| ser_clk | output | 1 | Serial bit clock |
| ser_data | output | 1 | Serial data, MSB first |
| tgt_sel | output | NUM_TGT | One select line per target |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse at transfer end |
| boot_err | output | 1 | One-cycle pulse for a rejected boot |

## Verification
The bench builds the loader with 16-bit words, an eight-word image, splice slots 2 and 5, a 4-bit divider and four targets. The short image keeps each boot to a few hundred cycles, so several boots can run back to back. Within that span the bench reaches divider values 0, 1 and 2, splices at a middle and a late index, a rejected boot mid-stream, and parameter writes that land during one transfer and take effect in the next.

// File: rtl/loader_pkg.sv
package loader_pkg;
  typedef enum logic [1:0] {
    OP_PHASE = 2'b00,
    OP_RATE  = 2'b01,
    OP_BOOT  = 2'b10,
    OP_DIV   = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'b00,
    SQ_LOAD  = 2'b01,
    SQ_SHIFT = 2'b10
  } sq_e;
endpackage

// File: rtl/loader_rom.sv
module loader_rom #(
  parameter int WORD_W    = 16,
  parameter int IMG_WORDS = 16,
  localparam int AW       = $clog2(IMG_WORDS)
) (
  input  logic [AW-1:0]     addr,
  output logic [WORD_W-1:0] data
);
  // Placeholder image content, computed rather than listed
  function automatic logic [WORD_W-1:0] img_word(input int k);
    return WORD_W'((32'(k) * 32'h1357) ^ 32'hC0DE);
  endfunction

  logic [WORD_W-1:0] tbl [IMG_WORDS];

  for (genvar g = 0; g < IMG_WORDS; g++) begin : g_word
    assign tbl[g] = img_word(g);
  end

  always_comb begin
    data = '0;
    for (int i = 0; i < IMG_WORDS; i++) begin
      if (addr == AW'(i)) data = tbl[i];
    end
  end
endmodule

// File: rtl/loader_cmd.sv
module loader_cmd
  import loader_pkg::*;
#(
  parameter int WORD_W  = 16,
  parameter int DIV_W   = 8,
  parameter int NUM_TGT = 4,
  parameter int DIV_RST = 1,
  localparam int TGT_W  = $clog2(NUM_TGT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [TGT_W-1:0]  cmd_tgt,
  input  logic [WORD_W-1:0] cmd_data,
  input  logic              busy,
  output logic [WORD_W-1:0] phase_q,
  output logic [WORD_W-1:0] rate_q,
  output logic [DIV_W-1:0]  div_q,
  output logic              boot_go,
  output logic [TGT_W-1:0]  boot_tgt,
  output logic              err_q
);
  logic              phase_en, rate_en, div_en, err_d;
  logic              is_boot;

  always_comb begin
    phase_en = cmd_valid && (op_e'(cmd_op) == OP_PHASE);
    rate_en  = cmd_valid && (op_e'(cmd_op) == OP_RATE);
    div_en   = cmd_valid && (op_e'(cmd_op) == OP_DIV);
    is_boot  = cmd_valid && (op_e'(cmd_op) == OP_BOOT);
    boot_go  = is_boot && !busy;
    err_d    = is_boot && busy;
    boot_tgt = cmd_tgt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      rate_q  <= '0;
      div_q   <= DIV_W'(DIV_RST);
      err_q   <= 1'b0;
    end else begin
      if (phase_en) phase_q <= cmd_data;
      if (rate_en)  rate_q  <= cmd_data;
      if (div_en)   div_q   <= cmd_data[DIV_W-1:0];
      err_q <= err_d;
    end
  end
endmodule

// File: rtl/loader_seq.sv
module loader_seq
  import loader_pkg::*;
#(
  parameter int WORD_W     = 16,
  parameter int IMG_WORDS  = 16,
  parameter int NUM_TGT    = 4,
  parameter int DIV_W      = 8,
  parameter int PHASE_SLOT = 3,
  parameter int RATE_SLOT  = 7,
  localparam int AW        = $clog2(IMG_WORDS),
  localparam int BW        = $clog2(WORD_W),
  localparam int TGT_W     = $clog2(NUM_TGT)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               boot_go,
  input  logic [TGT_W-1:0]   boot_tgt,
  input  logic [WORD_W-1:0]  phase_in,
  input  logic [WORD_W-1:0]  rate_in,
  input  logic [DIV_W-1:0]   div_in,
  output logic [AW-1:0]      rom_addr,
  input  logic [WORD_W-1:0]  rom_data,
  output logic               ser_clk,
  output logic               ser_data,
  output logic [NUM_TGT-1:0] tgt_sel,
  output logic               busy,
  output logic               done
);
  sq_e               st_q, st_d;
  logic [NUM_TGT-1:0] sel_q, sel_d;
  logic [AW-1:0]     idx_q, idx_d;
  logic [BW-1:0]     bit_q, bit_d;
  logic [DIV_W-1:0]  cnt_q, cnt_d;
  logic              sclk_q, sclk_d;
  logic [WORD_W-1:0] sh_q, sh_d;
  logic [WORD_W-1:0] ph_s, rt_s, ph_d, rt_d;
  logic [DIV_W-1:0]  dv_s, dv_d;
  logic              done_q, done_d;
  logic              tick, last_bit, last_word;
  logic [WORD_W-1:0] next_word;

  // Look one word ahead so the next word loads with no gap cycle
  assign rom_addr  = (st_q == SQ_LOAD) ? '0 : idx_q + AW'(1);
  assign tick      = (cnt_q == dv_s);
  assign last_bit  = (bit_q == BW'(WORD_W - 1));
  assign last_word = (idx_q == AW'(IMG_WORDS - 1));

  always_comb begin
    if (rom_addr == AW'(PHASE_SLOT))     next_word = ph_s;
    else if (rom_addr == AW'(RATE_SLOT)) next_word = rt_s;
    else                                 next_word = rom_data;
  end

  always_comb begin
    st_d   = st_q;
    sel_d  = sel_q;
    idx_d  = idx_q;
    bit_d  = bit_q;
    cnt_d  = cnt_q;
    sclk_d = sclk_q;
    sh_d   = sh_q;
    ph_d   = ph_s;
    rt_d   = rt_s;
    dv_d   = dv_s;
    done_d = 1'b0;
    unique case (st_q)
      SQ_IDLE: begin
        if (boot_go) begin
          st_d  = SQ_LOAD;
          sel_d = NUM_TGT'(1) << boot_tgt;
          ph_d  = phase_in;
          rt_d  = rate_in;
          dv_d  = div_in;
        end
      end
      SQ_LOAD: begin
        sh_d   = next_word;
        idx_d  = '0;
        bit_d  = '0;
        cnt_d  = '0;
        sclk_d = 1'b0;
        st_d   = SQ_SHIFT;
      end
      SQ_SHIFT: begin
        if (!tick) begin
          cnt_d = cnt_q + DIV_W'(1);
        end else begin
          cnt_d = '0;
          if (!sclk_q) begin
            sclk_d = 1'b1;
          end else begin
            sclk_d = 1'b0;
            if (!last_bit) begin
              bit_d = bit_q + BW'(1);
              sh_d  = sh_q << 1;
            end else if (!last_word) begin
              bit_d = '0;
              idx_d = idx_q + AW'(1);
              sh_d  = next_word;
            end else begin
              bit_d  = '0;
              st_d   = SQ_IDLE;
              sel_d  = '0;
              done_d = 1'b1;
            end
          end
        end
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      sel_q  <= '0;
      idx_q  <= '0;
      bit_q  <= '0;
      cnt_q  <= '0;
      sclk_q <= 1'b0;
      sh_q   <= '0;
      ph_s   <= '0;
      rt_s   <= '0;
      dv_s   <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      sel_q  <= sel_d;
      idx_q  <= idx_d;
      bit_q  <= bit_d;
      cnt_q  <= cnt_d;
      sclk_q <= sclk_d;
      sh_q   <= sh_d;
      ph_s   <= ph_d;
      rt_s   <= rt_d;
      dv_s   <= dv_d;
      done_q <= done_d;
    end
  end

  assign ser_clk  = sclk_q;
  assign ser_data = sh_q[WORD_W-1];
  assign tgt_sel  = sel_q;
  assign busy     = (st_q != SQ_IDLE);
  assign done     = done_q;
endmodule

// File: rtl/param_splice_loader.sv
module param_splice_loader #(
  parameter int WORD_W     = 16,
  parameter int IMG_WORDS  = 16,
  parameter int NUM_TGT    = 4,
  parameter int DIV_W      = 8,
  parameter int DIV_RST    = 1,
  parameter int PHASE_SLOT = 3,
  parameter int RATE_SLOT  = 7,
  localparam int AW        = $clog2(IMG_WORDS),
  localparam int TGT_W     = $clog2(NUM_TGT)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  input  logic [1:0]         cmd_op,
  input  logic [TGT_W-1:0]   cmd_tgt,
  input  logic [WORD_W-1:0]  cmd_data,
  output logic               ser_clk,
  output logic               ser_data,
  output logic [NUM_TGT-1:0] tgt_sel,
  output logic               busy,
  output logic               done,
  output logic               boot_err
);
  logic [1:0]        rst_sync;
  logic              rst_int_n;
  logic [WORD_W-1:0] phase_q, rate_q, rom_data;
  logic [DIV_W-1:0]  div_q;
  logic              boot_go;
  logic [TGT_W-1:0]  boot_tgt;
  logic [AW-1:0]     rom_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  loader_cmd #(
    .WORD_W(WORD_W), .DIV_W(DIV_W), .NUM_TGT(NUM_TGT), .DIV_RST(DIV_RST)
  ) u_cmd (
    .clk(clk), .rst_n(rst_int_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_tgt(cmd_tgt), .cmd_data(cmd_data), .busy(busy),
    .phase_q(phase_q), .rate_q(rate_q), .div_q(div_q),
    .boot_go(boot_go), .boot_tgt(boot_tgt), .err_q(boot_err)
  );

  loader_rom #(.WORD_W(WORD_W), .IMG_WORDS(IMG_WORDS)) u_rom (
    .addr(rom_addr), .data(rom_data)
  );

  loader_seq #(
    .WORD_W(WORD_W), .IMG_WORDS(IMG_WORDS), .NUM_TGT(NUM_TGT), .DIV_W(DIV_W),
    .PHASE_SLOT(PHASE_SLOT), .RATE_SLOT(RATE_SLOT)
  ) u_seq (
    .clk(clk), .rst_n(rst_int_n), .boot_go(boot_go), .boot_tgt(boot_tgt),
    .phase_in(phase_q), .rate_in(rate_q), .div_in(div_q),
    .rom_addr(rom_addr), .rom_data(rom_data),
    .ser_clk(ser_clk), .ser_data(ser_data), .tgt_sel(tgt_sel),
    .busy(busy), .done(done)
  );
endmodule

// File: rtl/loader_sva.sv
module loader_sva #(
  parameter int NUM_TGT = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ser_clk,
  input logic               ser_data,
  input logic [NUM_TGT-1:0] tgt_sel,
  input logic               busy,
  input logic               done,
  input logic               boot_err
);
  assert_sel_onehot0_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tgt_sel));
  assert_sel_matches_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_sel != '0) == busy);
  assert_sel_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(tgt_sel));
  assert_idle_clk_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !ser_clk);
  assert_data_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ser_clk && $past(ser_clk) |-> $stable(ser_data));
  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy));
  assert_err_when_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    boot_err |-> $past(busy));
endmodule

bind param_splice_loader loader_sva #(.NUM_TGT(NUM_TGT)) u_loader_sva (
  .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
  .tgt_sel(tgt_sel), .busy(busy), .done(done), .boot_err(boot_err)
);

// File: tb/tb_param_splice_loader.sv
`timescale 1ns/1ps
module tb_param_splice_loader;
  localparam int W   = 16;
  localparam int IMG = 8;
  localparam int NT  = 4;
  localparam int DW  = 4;
  localparam int PS  = 2;
  localparam int RS  = 5;

  logic          clk, rst_n, cmd_valid;
  logic [1:0]    cmd_op;
  logic [1:0]    cmd_tgt;
  logic [W-1:0]  cmd_data;
  logic          ser_clk, ser_data, busy, done, boot_err;
  logic [NT-1:0] tgt_sel;

  int n_chk, n_err, n_boot, n_done, cyc;
  logic [W-1:0]  m_phase, m_rate;
  logic [DW-1:0] m_div;
  logic [W-1:0]  q_word[$];
  logic [NT-1:0] q_sel[$];
  int            q_div[$];
  logic          prev_sclk, done_seen;
  logic [W-1:0]  acc;
  int            bitcnt, hi_cnt, mon_div;

  param_splice_loader #(
    .WORD_W(W), .IMG_WORDS(IMG), .NUM_TGT(NT), .DIV_W(DW), .DIV_RST(1),
    .PHASE_SLOT(PS), .RATE_SLOT(RS)
  ) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_tgt(cmd_tgt), .cmd_data(cmd_data), .ser_clk(ser_clk),
    .ser_data(ser_data), .tgt_sel(tgt_sel), .busy(busy), .done(done),
    .boot_err(boot_err)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input logic ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  function automatic logic [W-1:0] img(input int k);
    if (k == PS) return m_phase;
    if (k == RS) return m_rate;
    return W'((32'(k) * 32'h1357) ^ 32'hC0DE);
  endfunction

  task automatic send(input logic [1:0] op, input logic [1:0] tgt, input logic [W-1:0] d);
    @(posedge clk); #1;
    cmd_valid = 1'b1; cmd_op = op; cmd_tgt = tgt; cmd_data = d;
    @(posedge clk); #1;
    cmd_valid = 1'b0;
  endtask

  task automatic set_phase(input logic [W-1:0] v); m_phase = v; send(2'b00, 2'd0, v); endtask
  task automatic set_rate(input logic [W-1:0] v);  m_rate = v;  send(2'b01, 2'd0, v); endtask
  task automatic set_div(input logic [DW-1:0] v);  m_div = v;   send(2'b11, 2'd0, W'(v)); endtask

  // Driver: push the expected stream, then issue the boot
  task automatic boot(input logic [1:0] tgt);
    for (int k = 0; k < IMG; k++) begin
      q_word.push_back(img(k));
      q_sel.push_back(NT'(1) << tgt);
      q_div.push_back(int'(m_div));
    end
    done_seen = 1'b0;
    n_boot++;
    send(2'b10, tgt, '0);
    chk(busy == 1'b1, "R7 busy after boot", 32'(busy), 1);
    chk(tgt_sel == (NT'(1) << tgt), "R6 select on boot", 32'(tgt_sel), 32'(NT'(1) << tgt));
  endtask

  task automatic wait_done();
    while (!done_seen) @(negedge clk);
  endtask

  // Monitor: rebuild words from the serial line and compare with the queue
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (cyc > 150000) begin
        chk(1'b0, "watchdog", 32'(cyc), 150000);
        finish_run();
      end
      if (ser_clk && !prev_sclk) begin
        hi_cnt = 1;
        if (q_word.size() == 0) begin
          chk(1'b0, "R6 unexpected bit", 32'(tgt_sel), 0);
        end else begin
          mon_div = q_div[0];
          acc = {acc[W-2:0], ser_data};
          bitcnt++;
          if (bitcnt == W) begin
            logic [W-1:0]  ew;
            logic [NT-1:0] es;
            ew = q_word.pop_front();
            es = q_sel.pop_front();
            void'(q_div.pop_front());
            bitcnt = 0;
            chk(acc == ew, "R2 R3 R4 word content", 32'(acc), 32'(ew));
            chk(tgt_sel == es, "R6 R9 target of word", 32'(tgt_sel), 32'(es));
          end
        end
      end else if (ser_clk) begin
        hi_cnt++;
      end else if (prev_sclk) begin
        chk(hi_cnt == mon_div + 1, "R5 high phase length", 32'(hi_cnt), 32'(mon_div + 1));
      end
      if (done) begin
        n_done++;
        done_seen = 1'b1;
        chk(q_word.size() == 0 && bitcnt == 0, "R8 done after final word",
            32'(q_word.size()), 0);
        chk(!busy && tgt_sel == '0, "R8 idle at done", 32'({busy, tgt_sel}), 0);
      end
      prev_sclk = ser_clk;
    end
  end

  initial begin
    n_chk = 0; n_err = 0; n_boot = 0; n_done = 0; cyc = 0;
    prev_sclk = 1'b0; done_seen = 1'b0; acc = '0; bitcnt = 0; hi_cnt = 0; mon_div = 0;
    m_phase = '0; m_rate = '0; m_div = DW'(1);
    cmd_valid = 1'b0; cmd_op = 2'b00; cmd_tgt = 2'd0; cmd_data = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk(tgt_sel == '0, "R1 select", 32'(tgt_sel), 0);
    chk(!busy, "R1 busy", 32'(busy), 0);
    chk(!done, "R1 done", 32'(done), 0);
    chk(!boot_err, "R1 err", 32'(boot_err), 0);
    chk(!ser_clk, "R1 ser_clk", 32'(ser_clk), 0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R2 R3: splice with the reset divider
    set_phase(16'hABCD);
    set_rate(16'h1234);
    boot(2'd2);
    wait_done();

    // R5: fastest divider, extreme parameter words
    set_div(4'd0);
    set_phase(16'h0001);
    set_rate(16'hFFFF);
    boot(2'd0);
    wait_done();

    // R9 R10: rejected boot and parameter writes during a transfer
    set_div(4'd2);
    set_phase(16'h5A5A);
    set_rate(16'h0F0F);
    boot(2'd3);
    repeat (20) @(posedge clk);
    send(2'b10, 2'd1, '0);
    chk(boot_err == 1'b1, "R9 error raised", 32'(boot_err), 1);
    chk(tgt_sel == 4'b1000, "R9 target kept", 32'(tgt_sel), 32'(4'b1000));
    @(posedge clk); #1;
    chk(boot_err == 1'b0, "R9 error one cycle", 32'(boot_err), 0);
    set_phase(16'h7777);
    set_rate(16'h8888);
    set_div(4'd1);
    wait_done();

    // R10: the new values take effect on the next boot
    boot(2'd1);
    wait_done();

    // R6: booted targets stay untouched afterwards
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      chk(tgt_sel == '0 && !ser_clk, "R6 idle after boot", 32'({tgt_sel, ser_clk}), 0);
    end
    chk(n_done == n_boot, "R8 done count", 32'(n_done), 32'(n_boot));
    finish_run();
  end
endmodule